// File: doc/BRIEF.md
# Dual-Bus Local Memory Window Router

This block sits between a soft processor and its memories. The processor has an instruction fetch bus and a load/store data bus. On every request the block decides whether the request goes to a 16 KiB on-chip scratch SRAM or to a shared external memory port. Each bus has its own base and mask pair. A request hits the SRAM when its address ANDed with the mask equals the base. A request that misses is relocated and sent to the external port. The relocation adds an offset in 8-byte steps.

Both buses can hit the single SRAM port in the same cycle, and both can miss towards the single external port in the same cycle. In either case the data bus is served first. The instruction bus sees its ready signal held low and retries. Byte order is chosen separately for each bus. In big-endian mode the four byte lanes are reversed on write data, on byte enables and on returned read data. The external port carries a priority flag, which is taken from a read-priority setting or a write-priority setting depending on the direction of the access. It also carries a source tag, so that responses can be routed back to the right bus.

Top module: `lmem_window_router`

## Requirements
- R1: A request hits the SRAM exactly when (address AND mask) equals base, using the instruction-bus pair for fetches and the data-bus pair for loads and stores. A hit never produces an external request from that bus.
- R2: On an SRAM access the word index is address bits [13:2], one 32-bit word per index. Data-bus writes drive sramWe high; reads drive it low.
- R3: A missed request is presented on the external port with extAddr equal to its address plus {cpuBaseHi, 3'b000}, with wrap-around in 32 bits.
- R4: When both buses hit the SRAM in the same cycle, the data bus gets the SRAM port and iReady is low. In the next cycle the instruction request is accepted if it is still present alone.
- R5: The SRAM is read with one cycle of latency. In the cycle after an accepted read hit, the matching bus raises its rvalid and shows the SRAM word.
- R6: With dBigEnd = 1, the data bus reverses its byte lanes. Write data byte 0 (bits 7:0) is exchanged with byte 3 and byte 1 with byte 2. Byte-enable bit 0 is exchanged with bit 3 and bit 1 with bit 2. Returned read data is reversed the same way. With dBigEnd = 0 all three pass through unchanged.
- R7: With iBigEnd = 1, read data returned to the instruction bus has its four byte lanes reversed. With iBigEnd = 0 it is unchanged.
- R8: extPrio equals wrPrioHigh for an external write and rdPrioHigh for an external read.
- R9: When both buses miss in the same cycle, the data bus owns the external port (extId = 1) and iReady is low. An instruction-only miss drives extId = 0. A response with extRspId = 1 raises dRvalid; one with extRspId = 0 raises iRvalid. Either way the bus receives extRdata.
- R10: After reset, with no requests, iRvalid, dRvalid, sramEn and extValid are all low.
- R11: A missed request is accepted only when extReady is high. While extReady is low, the ready signal of the missing bus stays low and extValid stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| iBase | input | 32 | Instruction-bus SRAM window base |
| iMask | input | 32 | Instruction-bus SRAM window mask |
| dBase | input | 32 | Data-bus SRAM window base |
| dMask | input | 32 | Data-bus SRAM window mask |
| cpuBaseHi | input | 29 | Relocation offset bits [31:3] for external accesses |
| iBigEnd | input | 1 | Instruction-bus byte order, 1 = big-endian |
| dBigEnd | input | 1 | Data-bus byte order, 1 = big-endian |
| rdPrioHigh | input | 1 | Priority flag for external reads |
| wrPrioHigh | input | 1 | Priority flag for external writes |
| iValid | input | 1 | Instruction fetch request |
| iAddr | input | 32 | Fetch address |
| iReady | output | 1 | Fetch accepted this cycle |
| iRvalid | output | 1 | Fetch data valid |
| iRdata | output | 32 | Fetch data |
| dValid | input | 1 | Data request |
| dWrite | input | 1 | Data request is a write |
| dAddr | input | 32 | Data address |
| dWdata | input | 32 | Data write value |
| dBe | input | 4 | Data byte enables |
| dReady | output | 1 | Data request accepted this cycle |
| dRvalid | output | 1 | Load data valid |
| dRdata | output | 32 | Load data |
| sramEn | output | 1 | SRAM access strobe |
| sramWe | output | 1 | SRAM write |
| sramIdx | output | 12 | SRAM word index |
| sramWdata | output | 32 | SRAM write data |
| sramBe | output | 4 | SRAM byte enables |
| sramRdata | input | 32 | SRAM read data, one cycle after sramEn |
| extValid | output | 1 | External request valid |
| extReady | input | 1 | External port accepts request |
| extWrite | output | 1 | External request is a write |
| extAddr | output | 32 | Relocated external address |
| extWdata | output | 32 | External write data |
| extBe | output | 4 | External byte enables |
| extPrio | output | 1 | External access priority |
| extId | output | 1 | Request source, 1 = data bus, 0 = instruction bus |
| extRvalid | input | 1 | External read response valid |
| extRspId | input | 1 | Response source tag |
| extRdata | input | 32 | External read data |

## Verification
Four properties are checked on every cycle:
- the data bus wins an SRAM conflict;
- an accepted SRAM read hit produces rvalid exactly one cycle later;
- a miss stalls while the external port refuses it;
- the priority flag follows the access direction.

Some behaviour can only be shown by the bench's scenarios, because it concerns values rather than timing: the relocated address arithmetic, the index bits taken from the address, the byte-lane reversal on data, enables and read data, the routing of tagged external responses, and a change of mask that moves the window. The bench models the SRAM and the external memory to observe these.

// File: rtl/lwr_pkg.sv
package lwr_pkg;

  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;

  typedef struct packed {
    logic dSram;     // data bus owns SRAM this cycle
    logic iSram;     // instruction bus owns SRAM this cycle
    logic dExt;      // data bus owns external port
    logic iExt;      // instruction bus owns external port
    logic dRspSram;  // data response comes from SRAM
    logic iRspSram;  // instruction response comes from SRAM
  } lwrStrobe_t;

  function automatic logic [WORD_W-1:0] laneSwap(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < WORD_BYTES; k++)
      r[8*k +: 8] = v[8*(WORD_BYTES-1-k) +: 8];
    return r;
  endfunction

  function automatic logic [WORD_BYTES-1:0] beSwap(input logic [WORD_BYTES-1:0] v);
    logic [WORD_BYTES-1:0] r;
    for (int k = 0; k < WORD_BYTES; k++)
      r[k] = v[WORD_BYTES-1-k];
    return r;
  endfunction

endpackage

// File: rtl/lwr_hit_cmp.sv
module lwr_hit_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit
);
  always_comb hit = ((addr & mask) == base);
endmodule

// File: rtl/lwr_ctrl.sv
module lwr_ctrl
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] iBase,
  input  logic [ADDR_W-1:0] iMask,
  input  logic [ADDR_W-1:0] dBase,
  input  logic [ADDR_W-1:0] dMask,
  input  logic              iValid,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic              dValid,
  input  logic              dWrite,
  input  logic [ADDR_W-1:0] dAddr,
  input  logic              extReady,
  input  logic              extRvalid,
  input  logic              extRspId,
  output logic              iReady,
  output logic              dReady,
  output logic              iRvalid,
  output logic              dRvalid,
  output lwrStrobe_t        strb
);

  localparam int NBUS = 2;  // index 0 = instruction, 1 = data

  logic [NBUS-1:0]       hitVec;
  logic [ADDR_W-1:0]     addrArr [NBUS];
  logic [ADDR_W-1:0]     baseArr [NBUS];
  logic [ADDR_W-1:0]     maskArr [NBUS];

  always_comb begin
    addrArr[0] = iAddr; baseArr[0] = iBase; maskArr[0] = iMask;
    addrArr[1] = dAddr; baseArr[1] = dBase; maskArr[1] = dMask;
  end

  for (genvar b = 0; b < NBUS; b++) begin : gHit
    lwr_hit_cmp #(.ADDR_W(ADDR_W)) uHit (
      .addr(addrArr[b]),
      .base(baseArr[b]),
      .mask(maskArr[b]),
      .hit (hitVec[b])
    );
  end

  logic iHit, dHit;
  assign iHit = hitVec[0];
  assign dHit = hitVec[1];

  logic dSramReq, iSramReq, dExtReq, iExtReq;
  always_comb begin
    dSramReq = dValid & dHit;
    iSramReq = iValid & iHit & ~dSramReq;
    dExtReq  = dValid & ~dHit;
    iExtReq  = iValid & ~iHit & ~dExtReq;
  end

  always_comb begin
    dReady = dHit ? 1'b1 : extReady;
    iReady = iHit ? ~dSramReq : (~dExtReq & extReady);
  end

  logic dPend, iPend;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dPend <= 1'b0;
      iPend <= 1'b0;
    end else begin
      dPend <= dSramReq & ~dWrite;
      iPend <= iSramReq;
    end
  end

  always_comb begin
    dRvalid = dPend | (extRvalid & extRspId);
    iRvalid = iPend | (extRvalid & ~extRspId);
  end

  always_comb begin
    strb.dSram    = dSramReq;
    strb.iSram    = iSramReq;
    strb.dExt     = dExtReq;
    strb.iExt     = iExtReq;
    strb.dRspSram = dPend;
    strb.iRspSram = iPend;
  end

  AST_DATA_WINS_SRAM: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dHit && iValid && iHit) |-> !iReady); // R4

  AST_D_SRAM_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dHit && !dWrite) |=> dRvalid); // R5

  AST_I_SRAM_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (iValid && iReady && iHit) |=> iRvalid); // R5

  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && !dHit && !extReady) |-> !dReady); // R11

endmodule

// File: rtl/lwr_datapath.sv
module lwr_datapath
  import lwr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SRAM_BYTES = 16384
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lwrStrobe_t            strb,
  input  logic [ADDR_W-4:0]     cpuBaseHi,
  input  logic                  iBigEnd,
  input  logic                  dBigEnd,
  input  logic                  rdPrioHigh,
  input  logic                  wrPrioHigh,
  input  logic [ADDR_W-1:0]     iAddr,
  input  logic                  dWrite,
  input  logic [ADDR_W-1:0]     dAddr,
  input  logic [WORD_W-1:0]     dWdata,
  input  logic [WORD_BYTES-1:0] dBe,
  input  logic [WORD_W-1:0]     sramRdata,
  input  logic [WORD_W-1:0]     extRdata,
  output logic                  sramEn,
  output logic                  sramWe,
  output logic [$clog2(SRAM_BYTES/WORD_BYTES)-1:0] sramIdx,
  output logic [WORD_W-1:0]     sramWdata,
  output logic [WORD_BYTES-1:0] sramBe,
  output logic                  extValid,
  output logic                  extWrite,
  output logic [ADDR_W-1:0]     extAddr,
  output logic [WORD_W-1:0]     extWdata,
  output logic [WORD_BYTES-1:0] extBe,
  output logic                  extPrio,
  output logic                  extId,
  output logic [WORD_W-1:0]     iRdata,
  output logic [WORD_W-1:0]     dRdata
);

  localparam int IDX_W = $clog2(SRAM_BYTES / WORD_BYTES);
  localparam int IDX_LO = $clog2(WORD_BYTES);
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [ADDR_W-1:0]     relocOffset;
  logic [WORD_W-1:0]     dWdataLane;
  logic [WORD_BYTES-1:0] dBeLane;

  always_comb begin
    relocOffset = {cpuBaseHi, 3'b000};
    dWdataLane  = dBigEnd ? laneSwap(dWdata) : dWdata;
    dBeLane     = dBigEnd ? beSwap(dBe) : dBe;
  end

  // SRAM port
  always_comb begin
    sramEn    = strb.dSram | strb.iSram;
    sramWe    = strb.dSram & dWrite;
    sramIdx   = strb.dSram ? dAddr[IDX_HI:IDX_LO] : iAddr[IDX_HI:IDX_LO];
    sramWdata = dWdataLane;
    sramBe    = strb.dSram ? dBeLane : {WORD_BYTES{1'b1}};
  end

  // External port
  always_comb begin
    extValid = strb.dExt | strb.iExt;
    extWrite = strb.dExt & dWrite;
    extAddr  = (strb.dExt ? dAddr : iAddr) + relocOffset;
    extWdata = dWdataLane;
    extBe    = strb.dExt ? dBeLane : {WORD_BYTES{1'b1}};
    extPrio  = extWrite ? wrPrioHigh : rdPrioHigh;
    extId    = strb.dExt;
  end

  // Response steering and byte order
  logic [WORD_W-1:0] dRaw, iRaw;
  always_comb begin
    dRaw   = strb.dRspSram ? sramRdata : extRdata;
    iRaw   = strb.iRspSram ? sramRdata : extRdata;
    dRdata = dBigEnd ? laneSwap(dRaw) : dRaw;
    iRdata = iBigEnd ? laneSwap(iRaw) : iRaw;
  end

  AST_EXT_PRIO_DIR: assert property (@(posedge clk) disable iff (!rstN)
    extValid |-> (extPrio == (extWrite ? wrPrioHigh : rdPrioHigh))); // R8

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    !(sramWe && extWrite)); // R1

endmodule

// File: rtl/lmem_window_router.sv
module lmem_window_router (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] iBase,
  input  logic [31:0] iMask,
  input  logic [31:0] dBase,
  input  logic [31:0] dMask,
  input  logic [28:0] cpuBaseHi,
  input  logic        iBigEnd,
  input  logic        dBigEnd,
  input  logic        rdPrioHigh,
  input  logic        wrPrioHigh,
  input  logic        iValid,
  input  logic [31:0] iAddr,
  output logic        iReady,
  output logic        iRvalid,
  output logic [31:0] iRdata,
  input  logic        dValid,
  input  logic        dWrite,
  input  logic [31:0] dAddr,
  input  logic [31:0] dWdata,
  input  logic [3:0]  dBe,
  output logic        dReady,
  output logic        dRvalid,
  output logic [31:0] dRdata,
  output logic        sramEn,
  output logic        sramWe,
  output logic [11:0] sramIdx,
  output logic [31:0] sramWdata,
  output logic [3:0]  sramBe,
  input  logic [31:0] sramRdata,
  output logic        extValid,
  input  logic        extReady,
  output logic        extWrite,
  output logic [31:0] extAddr,
  output logic [31:0] extWdata,
  output logic [3:0]  extBe,
  output logic        extPrio,
  output logic        extId,
  input  logic        extRvalid,
  input  logic        extRspId,
  input  logic [31:0] extRdata
);

  localparam int ADDR_W     = 32;
  localparam int SRAM_BYTES = 16384;

  lwr_pkg::lwrStrobe_t strb;

  lwr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .iBase    (iBase),
    .iMask    (iMask),
    .dBase    (dBase),
    .dMask    (dMask),
    .iValid   (iValid),
    .iAddr    (iAddr),
    .dValid   (dValid),
    .dWrite   (dWrite),
    .dAddr    (dAddr),
    .extReady (extReady),
    .extRvalid(extRvalid),
    .extRspId (extRspId),
    .iReady   (iReady),
    .dReady   (dReady),
    .iRvalid  (iRvalid),
    .dRvalid  (dRvalid),
    .strb     (strb)
  );

  lwr_datapath #(.ADDR_W(ADDR_W), .SRAM_BYTES(SRAM_BYTES)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cpuBaseHi (cpuBaseHi),
    .iBigEnd   (iBigEnd),
    .dBigEnd   (dBigEnd),
    .rdPrioHigh(rdPrioHigh),
    .wrPrioHigh(wrPrioHigh),
    .iAddr     (iAddr),
    .dWrite    (dWrite),
    .dAddr     (dAddr),
    .dWdata    (dWdata),
    .dBe       (dBe),
    .sramRdata (sramRdata),
    .extRdata  (extRdata),
    .sramEn    (sramEn),
    .sramWe    (sramWe),
    .sramIdx   (sramIdx),
    .sramWdata (sramWdata),
    .sramBe    (sramBe),
    .extValid  (extValid),
    .extWrite  (extWrite),
    .extAddr   (extAddr),
    .extWdata  (extWdata),
    .extBe     (extBe),
    .extPrio   (extPrio),
    .extId     (extId),
    .iRdata    (iRdata),
    .dRdata    (dRdata)
  );

  AST_DHIT_NO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && ((dAddr & dMask) == dBase)) |-> !(extValid && extId)); // R1

endmodule

// File: tb/lmem_window_router_test.sv
module lmem_window_router_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] iBase, iMask, dBase, dMask;
  logic [28:0] cpuBaseHi;
  logic        iBigEnd, dBigEnd, rdPrioHigh, wrPrioHigh;
  logic        iValid;
  logic [31:0] iAddr;
  logic        iReady, iRvalid;
  logic [31:0] iRdata;
  logic        dValid, dWrite;
  logic [31:0] dAddr, dWdata;
  logic [3:0]  dBe;
  logic        dReady, dRvalid;
  logic [31:0] dRdata;
  logic        sramEn, sramWe;
  logic [11:0] sramIdx;
  logic [31:0] sramWdata;
  logic [3:0]  sramBe;
  logic [31:0] sramRdata;
  logic        extValid, extReady, extWrite, extPrio, extId;
  logic [31:0] extAddr, extWdata;
  logic [3:0]  extBe;
  logic        extRvalid, extRspId;
  logic [31:0] extRdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  lmem_window_router uut (.*);

  // SRAM model: one-cycle read latency
  logic [31:0] mem [0:4095];
  initial for (int k = 0; k < 4096; k++) mem[k] = 32'hCAFE0000 | k;
  always @(posedge clk) begin
    if (sramEn) begin
      if (sramWe) begin
        for (int b = 0; b < 4; b++)
          if (sramBe[b]) mem[sramIdx][8*b +: 8] <= sramWdata[8*b +: 8];
      end else begin
        sramRdata <= mem[sramIdx];
      end
    end
  end

  // External memory model: read response next cycle, data = addr ^ 5A5A0000
  always @(posedge clk) begin
    if (!rstN) begin
      extRvalid <= 1'b0;
      extRspId  <= 1'b0;
      extRdata  <= '0;
    end else begin
      extRvalid <= extValid && extReady && !extWrite;
      extRspId  <= extId;
      extRdata  <= extAddr ^ 32'h5A5A0000;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    iValid = 0; dValid = 0; dWrite = 0; iAddr = '0; dAddr = '0; dWdata = '0; dBe = '0;
  endtask

  task automatic nextCycle();
    @(negedge clk);
    idle();
    #2;
  endtask

  task automatic testReset();
    chk("R10 iRvalid", {31'b0, iRvalid}, 32'd0);
    chk("R10 dRvalid", {31'b0, dRvalid}, 32'd0);
    chk("R10 sramEn", {31'b0, sramEn}, 32'd0);
    chk("R10 extValid", {31'b0, extValid}, 32'd0);
  endtask

  task automatic testDataHitWriteRead();
    @(negedge clk);
    dValid = 1; dWrite = 1; dAddr = 32'h0002_0010; dWdata = 32'h11223344; dBe = 4'b0011;
    #2;
    chk("R1 sramEn on hit", {31'b0, sramEn}, 32'd1);
    chk("R1 no ext on hit", {31'b0, extValid}, 32'd0);
    chk("R2 sramWe write", {31'b0, sramWe}, 32'd1);
    chk("R2 index", {20'b0, sramIdx}, 32'd4);
    chk("R6 little wdata", sramWdata, 32'h11223344);
    chk("R6 little be", {28'b0, sramBe}, 32'h3);
    @(negedge clk);
    idle();
    dValid = 1; dWrite = 0; dAddr = 32'h0002_0010;
    #2;
    chk("R2 sramWe read", {31'b0, sramWe}, 32'd0);
    nextCycle();
    chk("R5 dRvalid", {31'b0, dRvalid}, 32'd1);
    chk("R5 dRdata", dRdata, 32'hCAFE3344);
    nextCycle();
    chk("R5 dRvalid drops", {31'b0, dRvalid}, 32'd0);
  endtask

  task automatic testDataMiss();
    @(negedge clk);
    dValid = 1; dWrite = 0; dAddr = 32'h0000_1234;
    #2;
    chk("R1 miss no sram", {31'b0, sramEn}, 32'd0);
    chk("R3 extValid", {31'b0, extValid}, 32'd1);
    chk("R3 extAddr", extAddr, 32'h0080_1234);
    chk("R8 read prio", {31'b0, extPrio}, 32'd0);
    chk("R9 extId data", {31'b0, extId}, 32'd1);
    nextCycle();
    chk("R9 dRvalid ext", {31'b0, dRvalid}, 32'd1);
    chk("R9 iRvalid quiet", {31'b0, iRvalid}, 32'd0);
    chk("R9 dRdata ext", dRdata, 32'h5ADA_1234);
    @(negedge clk);
    dValid = 1; dWrite = 1; dAddr = 32'hFFFF_FFF8; dWdata = 32'h1; dBe = 4'hF;
    #2;
    chk("R8 write prio", {31'b0, extPrio}, 32'd1);
    chk("R3 wrap addr", extAddr, 32'h007F_FFF8);
    nextCycle();
  endtask

  task automatic testConflict();
    @(negedge clk);
    iValid = 1; iAddr = 32'h0001_0008;
    dValid = 1; dWrite = 0; dAddr = 32'h0002_0020;
    #2;
    chk("R4 iReady low", {31'b0, iReady}, 32'd0);
    chk("R4 dReady high", {31'b0, dReady}, 32'd1);
    chk("R4 data index", {20'b0, sramIdx}, 32'd8);
    @(negedge clk);
    dValid = 0;
    #2;
    chk("R5 dRvalid after conflict", {31'b0, dRvalid}, 32'd1);
    chk("R5 dRdata after conflict", dRdata, 32'hCAFE0008);
    chk("R4 iReady retry", {31'b0, iReady}, 32'd1);
    chk("R4 inst index", {20'b0, sramIdx}, 32'd2);
    nextCycle();
    chk("R5 iRvalid", {31'b0, iRvalid}, 32'd1);
    chk("R5 iRdata", iRdata, 32'hCAFE0002);
  endtask

  task automatic testBigEndian();
    dBigEnd = 1;
    @(negedge clk);
    dValid = 1; dWrite = 1; dAddr = 32'h0002_0040; dWdata = 32'hAABBCCDD; dBe = 4'b0001;
    #2;
    chk("R6 big wdata", sramWdata, 32'hDDCCBBAA);
    chk("R6 big be", {28'b0, sramBe}, 32'h8);
    @(negedge clk);
    idle();
    dValid = 1; dWrite = 0; dAddr = 32'h0002_0040;
    nextCycle();
    chk("R6 big rdata", dRdata, 32'h1000FEDD);
    dBigEnd = 0;
    iBigEnd = 1;
    @(negedge clk);
    iValid = 1; iAddr = 32'h0001_0004;
    nextCycle();
    chk("R7 big fetch", iRdata, 32'h0100FECA);
    iBigEnd = 0;
    @(negedge clk);
    iValid = 1; iAddr = 32'h0001_0004;
    nextCycle();
    chk("R7 little fetch", iRdata, 32'hCAFE0001);
  endtask

  task automatic testBackpressure();
    extReady = 0;
    @(negedge clk);
    dValid = 1; dWrite = 0; dAddr = 32'h0000_0100;
    iValid = 1; iAddr = 32'h0000_0200;
    #2;
    chk("R11 dReady low", {31'b0, dReady}, 32'd0);
    chk("R11 extValid held", {31'b0, extValid}, 32'd1);
    chk("R9 data owns ext", {31'b0, extId}, 32'd1);
    chk("R9 iReady low", {31'b0, iReady}, 32'd0);
    @(negedge clk);
    dValid = 0; extReady = 1;
    #2;
    chk("R9 inst id", {31'b0, extId}, 32'd0);
    chk("R9 iReady", {31'b0, iReady}, 32'd1);
    chk("R3 inst reloc", extAddr, 32'h0080_0200);
    nextCycle();
    chk("R9 iRvalid ext", {31'b0, iRvalid}, 32'd1);
    chk("R9 dRvalid quiet", {31'b0, dRvalid}, 32'd0);
    chk("R9 iRdata ext", iRdata, 32'h5ADA_0200);
  endtask

  task automatic testMaskChange();
    dMask = 32'hFFFF_0000; dBase = 32'h0003_0000;
    @(negedge clk);
    dValid = 1; dWrite = 0; dAddr = 32'h0003_9004;
    #2;
    chk("R1 wide mask hit", {31'b0, sramEn}, 32'd1);
    chk("R2 wide mask index", {20'b0, sramIdx}, 32'h401);
    @(negedge clk);
    dAddr = 32'h0002_0010;
    #2;
    chk("R1 old window misses", {31'b0, extValid}, 32'd1);
    nextCycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 0;
    iBase = 32'h0001_0000; iMask = 32'hFFFF_C000;
    dBase = 32'h0002_0000; dMask = 32'hFFFF_C000;
    cpuBaseHi = 29'h0010_0000;
    iBigEnd = 0; dBigEnd = 0; rdPrioHigh = 0; wrPrioHigh = 1;
    extReady = 1;
    sramRdata = '0;
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    #2;
    testReset();
    testDataHitWriteRead();
    testDataMiss();
    testConflict();
    testBigEndian();
    testBackpressure();
    testMaskChange();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule